// File: doc/BRIEF.md
# Push-Button Adding Calculator

This block adds two small unsigned operands and shows the total on a bank of result lines that hold their value between commands. Two push buttons drive it: one loads the sum of the current operands into the result register, and the other wipes that register to zero. Each button passes through a two-flop synchroniser and a rising-edge detector. Holding a button down therefore triggers exactly one operation.

A three-state Moore controller turns each detected press into a single-cycle strobe for the datapath. The Add press gives a load strobe and the clear press gives a clear strobe. The controller's state code is brought out on a port so that it can be watched in simulation. An asynchronous, active-high reset returns the controller to its waiting state and empties the result register.

Top module: `addCalc`

## Requirements
- R1: The result is the sum of the two operands, each zero-extended from OPER_W to RES_W bits before adding, so 15 + 15 gives 30 at the default widths.
- R2: While `rst` is high, whether it is applied at start-up or asynchronously in the middle of operation, `result` is 0 and `fsmState` is 0 (Idle), with no clock edge needed.
- R3: A rising edge on `addBtn`, first sampled at clock edge E0, makes `fsmState` read 1 (LoadSum) after edge E2 and makes `result` show the operand sum after edge E3.
- R4: A rising edge on `clearBtn` makes `fsmState` read 2 (Clear) for one cycle, and `result` is then 0.
- R5: When no command is detected, `result` holds its value even if the operands change.
- R6: A button held high causes only one operation. Operand changes made during the hold, and the later release, leave `result` unchanged.
- R7: When both buttons rise in the same cycle, the clear wins: the state goes to 2 and `result` becomes 0.
- R8: State codes are 0 = Idle, 1 = LoadSum and 2 = Clear. LoadSum and Clear each last exactly one cycle and are always followed by Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| addBtn | input | 1 | Raw Add push button |
| clearBtn | input | 1 | Raw clear-all push button |
| opA | input | OPER_W | First unsigned operand |
| opB | input | OPER_W | Second unsigned operand |
| result | output | RES_W | Held result register value |
| fsmState | output | 2 | Controller state code (0 Idle, 1 LoadSum, 2 Clear) |

## Verification
The hardest case to reach from the ports is a button held long enough for the operands to change while it is still down. A second load at that point would overwrite the register and hide the fault. The stimulus holds Add for more than ten cycles, swaps the operands after the first load has landed, and then releases the button, checking that the first sum is still there. Two further cases take care to set up. Both buttons are raised in the same cycle, and reset is asserted between clock edges with a non-zero result stored.

// File: rtl/calcPkg.sv
package calcPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_CLEAR = 2'd2
  } calcState_t;

  typedef struct packed {
    logic load;
    logic clear;
  } regStrobe_t;
endpackage

// File: rtl/calcBtnSync.sv
module calcBtnSync #(
  parameter int NUM_BTN = 2,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BTN-1:0] btnIn,
  output logic [NUM_BTN-1:0] btnRise
);
  localparam int LAST = STAGES - 1;

  genvar g;
  for (g = 0; g < NUM_BTN; g++) begin : gBit
    logic [STAGES-1:0] chain;
    logic              prevLevel;

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        chain     <= '0;
        prevLevel <= 1'b0;
      end else begin
        chain     <= {chain[STAGES-2:0], btnIn[g]};
        prevLevel <= chain[LAST];
      end
    end

    assign btnRise[g] = chain[LAST] & ~prevLevel;
  end
endmodule

// File: rtl/calcCtrl.sv
module calcCtrl
  import calcPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       addReq,
  input  logic       clrReq,
  output calcState_t state,
  output regStrobe_t strobe
);
  calcState_t stateNext;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = ST_IDLE;
    case (state)
      ST_IDLE: begin
        if (clrReq)      stateNext = ST_CLEAR;
        else if (addReq) stateNext = ST_LOAD;
        else             stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.load  = (state == ST_LOAD);
    strobe.clear = (state == ST_CLEAR);
  end
endmodule

// File: rtl/calcDatapath.sv
module calcDatapath
  import calcPkg::*;
#(
  parameter int OPER_W = 4,
  parameter int RES_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPER_W-1:0] opA,
  input  logic [OPER_W-1:0] opB,
  input  regStrobe_t        strobe,
  output logic [RES_W-1:0]  result
);
  localparam int PAD_W = RES_W - OPER_W;

  logic [RES_W-1:0] extA, extB, sum;

  assign extA = {{PAD_W{1'b0}}, opA};
  assign extB = {{PAD_W{1'b0}}, opB};
  assign sum  = extA + extB;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)               result <= '0;
    else if (strobe.clear) result <= '0;
    else if (strobe.load)  result <= sum;
  end
endmodule

// File: rtl/addCalc.sv
module addCalc
  import calcPkg::*;
#(
  parameter int OPER_W      = 4,
  parameter int RES_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addBtn,
  input  logic              clearBtn,
  input  logic [OPER_W-1:0] opA,
  input  logic [OPER_W-1:0] opB,
  output logic [RES_W-1:0]  result,
  output logic [1:0]        fsmState
);
  logic [1:0] btnRise;
  calcState_t state;
  regStrobe_t strobe;

  calcBtnSync #(.NUM_BTN(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .btnIn   ({clearBtn, addBtn}),
    .btnRise (btnRise)
  );

  calcCtrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .addReq (btnRise[0]),
    .clrReq (btnRise[1]),
    .state  (state),
    .strobe (strobe)
  );

  calcDatapath #(.OPER_W(OPER_W), .RES_W(RES_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .result (result)
  );

  assign fsmState = state;
endmodule

// File: rtl/calcChecker.sv
module calcChecker #(
  parameter int OPER_W = 4,
  parameter int RES_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [OPER_W-1:0] opA,
  input logic [OPER_W-1:0] opB,
  input logic [RES_W-1:0]  result,
  input logic [1:0]        fsmState,
  input logic              addRise,
  input logic              clrRise
);
  // R2: reset state held while rst is high
  always @(posedge clk) begin
    if (rst) begin
      a_r2_reset_state: assert (result == '0 && fsmState == 2'd0)
        else $error("reset state wrong");
    end
  end

  // R1, R3: load strobe captures zero-extended sum
  a_r3_load_sum: assert property (@(posedge clk) disable iff (rst)
    fsmState == 2'd1 |=> result == (RES_W'($past(opA)) + RES_W'($past(opB))));

  // R4: clear state empties the register
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
    fsmState == 2'd2 |=> result == '0);

  // R5: no change while idle
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    fsmState == 2'd0 |=> $stable(result));

  // R3: add edge alone starts a load
  a_r3_add_starts: assert property (@(posedge clk) disable iff (rst)
    (fsmState == 2'd0 && addRise && !clrRise) |=> fsmState == 2'd1);

  // R7: clear wins over add
  a_r7_clear_first: assert property (@(posedge clk) disable iff (rst)
    (fsmState == 2'd0 && clrRise) |=> fsmState == 2'd2);

  // R8: active states last one cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    fsmState != 2'd0 |=> fsmState == 2'd0);

  // R8: code stays in legal range
  a_r8_legal_code: assert property (@(posedge clk) disable iff (rst)
    fsmState != 2'd3);
endmodule

bind addCalc calcChecker #(.OPER_W(OPER_W), .RES_W(RES_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opA      (opA),
  .opB      (opB),
  .result   (result),
  .fsmState (fsmState),
  .addRise  (btnRise[0]),
  .clrRise  (btnRise[1])
);

// File: tb/test_addCalc.sv
module test_addCalc;
  localparam int OPER_W = 4;
  localparam int RES_W  = 8;

  typedef struct {
    int    res;
    int    code;
    string tag;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              addBtn = 1'b0;
  logic              clearBtn = 1'b0;
  logic [OPER_W-1:0] opA = '0;
  logic [OPER_W-1:0] opB = '0;
  logic [RES_W-1:0]  result;
  logic [1:0]        fsmState;

  int       testsRun = 0;
  int       testsFailed = 0;
  bit       running = 1'b0;
  bit       finished = 1'b0;
  expItem_t expQ[$];

  addCalc #(.OPER_W(OPER_W), .RES_W(RES_W)) i_addCalc (
    .clk      (clk),
    .rst      (rst),
    .addBtn   (addBtn),
    .clearBtn (clearBtn),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .fsmState (fsmState)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  // monitor: pops expected item when a non-idle state appears
  expItem_t cur;
  bit pending = 1'b0;
  always @(negedge clk) begin
    if (running && !rst) begin
      if (pending) begin
        pending = 1'b0;
        check(int'(result) == cur.res, cur.tag, int'(result), cur.res);
        check(fsmState == 2'd0, "R8 back to idle", int'(fsmState), 0);
      end else if (fsmState != 2'd0) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected operation", int'(fsmState), 0);
        end else begin
          cur = expQ.pop_front();
          check(int'(fsmState) == cur.code, "R8 state code", int'(fsmState), cur.code);
          pending = 1'b1;
        end
      end
    end
  end

  // driver: presses buttons and queues expected results
  task automatic press(input bit doAdd, input bit doClr, input int a, input int b,
                       input int hold, input string tag);
    expItem_t it;
    @(negedge clk);
    opA = OPER_W'(a);
    opB = OPER_W'(b);
    addBtn = doAdd;
    clearBtn = doClr;
    it.res  = doClr ? 0 : a + b;
    it.code = doClr ? 2 : 1;
    it.tag  = tag;
    expQ.push_back(it);
    repeat (hold) @(negedge clk);
    addBtn = 1'b0;
    clearBtn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #40;
    @(negedge clk);
    check(result == '0, "R2 reset result", int'(result), 0);
    check(fsmState == 2'd0, "R2 reset state", int'(fsmState), 0);
    rst = 1'b0;
    running = 1'b1;
    repeat (3) @(negedge clk);

    press(1, 0, 3, 4, 4, "R3 add 3+4");
    press(1, 0, 15, 15, 4, "R1 add 15+15");
    press(0, 1, 0, 0, 4, "R4 clear");
    press(1, 0, 0, 0, 2, "R1 add 0+0");
    press(1, 0, 9, 6, 3, "R3 add 9+6");

    // R5: operand change without command
    opA = 4'd1; opB = 4'd1;
    repeat (8) @(negedge clk);
    check(int'(result) == 15, "R5 hold", int'(result), 15);

    // R6: long hold with operand change
    begin
      expItem_t it;
      opA = 4'd1; opB = 4'd2; addBtn = 1'b1;
      it.res = 3; it.code = 1; it.tag = "R6 first load";
      expQ.push_back(it);
      repeat (6) @(negedge clk);
      opA = 4'd5; opB = 4'd5;
      repeat (8) @(negedge clk);
      check(int'(result) == 3, "R6 held button", int'(result), 3);
      addBtn = 1'b0;
      repeat (6) @(negedge clk);
      check(int'(result) == 3, "R6 release", int'(result), 3);
    end

    press(1, 0, 7, 8, 4, "R3 add 7+8");
    // R7: both at once, clear wins
    press(1, 1, 6, 6, 4, "R7 both pressed");
    check(result == '0, "R7 result", int'(result), 0);

    press(1, 0, 12, 2, 4, "R1 add 12+2");
    // R2: asynchronous reset mid-run
    running = 1'b0;
    @(negedge clk);
    #2 rst = 1'b1;
    #1;
    check(result == '0, "R2 async reset result", int'(result), 0);
    check(fsmState == 2'd0, "R2 async reset state", int'(fsmState), 0);
    @(negedge clk);
    rst = 1'b0;
    running = 1'b1;
    press(1, 0, 2, 5, 4, "R3 add after reset");

    check(expQ.size() == 0, "R3 all operations seen", expQ.size(), 0);
    finish_run();
  end
endmodule